// File: doc/BRIEF.md
# Device Interrupt Gating and Signalling Unit

This unit sits between the event sources of a USB device controller and the single interrupt line to the host processor. Every endpoint and six bus conditions (bus reset, suspend, resume, start-of-frame, missed start-of-frame, end-of-transfer) each raise a one-bit event input. A rising edge on an event input is recorded in a 32-bit status register only if that event's enable bit was already set. Events that are not enabled are dropped before they reach the status register. The enable bits do not mask a status that has already been latched.

Software reaches the unit through a byte-wide command port followed by 16-bit data words, always the low word first. The commands read and write the enable register, read the status register, clear status bits by writing 1s to them, and read and write a small configuration word. The configuration word holds a global interrupt enable, a level or pulse mode selector and the pin polarity. In level mode the pin stays active while any status bit is pending. In pulse mode each newly latched event gives one pulse of fixed length.

Top module: `dint_unit`

## Requirements
- R1: After the power-on reset `rst_ni`, the enable, status and configuration registers read as zero, and `int_o` is high (inactive, active-low polarity).
- R2: Command 0xC2 writes the 32-bit enable register as two words, bits 15:0 first. Command 0xC3 returns it the same way on `rd_data_o`, and each `data_re_i` strobe advances to the next word.
- R3: The event map is: bit 0 bus reset, bit 1 suspend, bit 2 resume, bit 3 start-of-frame, bit 4 missed start-of-frame, bit 5 end-of-transfer, bits 6 and up endpoints 0..N_EP-1. A rising edge on an enabled event sets its status bit on that clock edge. Command 0xC0 reads the status as two words, low word first. Unused status bits read zero.
- R4: A rising edge on an event whose enable bit is clear leaves the status register unchanged and does not assert `int_o`.
- R5: Setting an enable bit while its event input is already high does not latch that event. An enable write in the same cycle as the event's rising edge does not latch it either.
- R6: Command 0xC1 clears the status bits written as 1, one word at a time, low word first. If a clear and a new latch fall on the same bit in the same cycle, the bit stays set.
- R7: In level mode (configuration bit 1 = 0) with the global enable set, the pin is active while any status bit is set. It goes inactive right after the clock edge that clears the last pending bit.
- R8: In pulse mode (configuration bit 1 = 1) each clock edge that latches one or more events starts one active pulse of exactly PULSE_CYC cycles, even if status bits stay pending.
- R9: Configuration bit 2 sets the polarity: 0 means the pin is driven low when active, 1 means it is driven high when active.
- R10: With the global enable (configuration bit 0) clear, `int_o` stays inactive but events still latch. Setting the global enable in level mode then asserts the pin for the pending status.
- R11: A bus reset event (event bit 0) is latched like any other event and leaves the enable and configuration registers unchanged.
- R12: Command 0xBA writes the configuration word in a single data word (bit 0 global enable, bit 1 mode, bit 2 polarity). Command 0xBB reads it back with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| cmd_we_i | input | 1 | Strobe: start a command with `cmd_i` |
| cmd_i | input | 8 | Command code |
| data_we_i | input | 1 | Strobe: write `wr_data_i` as the next word |
| data_re_i | input | 1 | Strobe: current read word consumed, advance |
| wr_data_i | input | WORD_W | Write data word |
| rd_data_o | output | WORD_W | Current read word of the active command |
| bus_evt_i | input | 6 | Bus event inputs, map as in R3 |
| ep_evt_i | input | N_EP | Endpoint event inputs |
| int_o | output | 1 | Interrupt pin |

## Verification
Two functions can act on one status bit in the same clock cycle.

- **Enable write against capture:** an enable write and that event's rising edge fall in one cycle. The bench drives the enable data word and raises the event input in the same cycle. It then expects the status to read zero. A later clean edge must then latch, which shows the bit was really enabled.
- **Clear against new latch:** a write-1-to-clear and a new rising edge fall on the same pending bit in one cycle. The bench expects the bit to survive that cycle. A following plain clear must then empty the status.

// File: rtl/dint_pkg.sv
package dint_pkg;
  localparam int NUM_BUS_EVT = 6;

  typedef enum logic [7:0] {
    CMD_STAT_RD  = 8'hC0,
    CMD_STAT_CLR = 8'hC1,
    CMD_EN_WR    = 8'hC2,
    CMD_EN_RD    = 8'hC3,
    CMD_CFG_WR   = 8'hBA,
    CMD_CFG_RD   = 8'hBB
  } cmd_e;

  typedef struct packed {
    logic pol;     // 1: active high
    logic pulse;   // 1: pulse mode
    logic irq_en;  // global pin enable
  } cfg_t;
endpackage

// File: rtl/dint_regs.sv
module dint_regs
  import dint_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic [7:0]        cmd_i,
  input  logic              data_we_i,
  input  logic              data_re_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [REG_W-1:0]  status_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic [REG_W-1:0]  enable_o,
  output logic [REG_W-1:0]  clr_mask_o,
  output logic              en_wr_o,
  output cfg_t              cfg_o
);
  localparam int NWORDS = REG_W / WORD_W;
  localparam int IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1;

  logic [7:0]                   cmd_q;
  logic [IDX_W-1:0]             idx_q;
  logic [NWORDS-1:0][WORD_W-1:0] en_q, st_w, clr_w;
  cfg_t                         cfg_q;

  assign st_w = status_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
      idx_q <= '0;
    end else if (cmd_we_i) begin
      cmd_q <= cmd_i;
      idx_q <= '0;
    end else if (data_we_i || data_re_i) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assign en_wr_o = data_we_i && (cmd_q == CMD_EN_WR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else if (en_wr_o) en_q[idx_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else if (data_we_i && cmd_q == CMD_CFG_WR && idx_q == '0)
      cfg_q <= cfg_t'(wr_data_i[2:0]);
  end

  for (genvar w = 0; w < NWORDS; w++) begin : g_clr
    assign clr_w[w] = (data_we_i && cmd_q == CMD_STAT_CLR && idx_q == IDX_W'(w))
                      ? wr_data_i : '0;
  end

  always_comb begin
    rd_data_o = '0;
    case (cmd_q)
      CMD_EN_RD:   rd_data_o = en_q[idx_q];
      CMD_STAT_RD: rd_data_o = st_w[idx_q];
      CMD_CFG_RD:  if (idx_q == '0) rd_data_o = WORD_W'(cfg_q);
      default:     rd_data_o = '0;
    endcase
  end

  assign enable_o   = en_q;
  assign clr_mask_o = clr_w;
  assign cfg_o      = cfg_q;
endmodule

// File: rtl/dint_capture.sv
module dint_capture #(
  parameter int REG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] evt_i,
  input  logic [REG_W-1:0] enable_i,
  input  logic [REG_W-1:0] clr_i,
  output logic [REG_W-1:0] status_o,
  output logic             new_o
);
  logic [REG_W-1:0] evt_q, set_w, status_q;

  // enable sampled as held before this edge; late enable sees no edge
  assign set_w = evt_i & ~evt_q & enable_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q    <= '0;
      status_q <= '0;
    end else begin
      evt_q    <= evt_i;
      status_q <= (status_q & ~clr_i) | set_w;  // set wins
    end
  end

  assign status_o = status_q;
  assign new_o    = |set_w;
endmodule

// File: rtl/dint_pin.sv
module dint_pin
  import dint_pkg::*;
#(
  parameter int PULSE_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  cfg_t cfg_i,
  input  logic pending_i,
  input  logic new_i,
  output logic int_o
);
  localparam int CNT_W = $clog2(PULSE_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (cfg_i.pulse && cfg_i.irq_en && new_i) cnt_q <= CNT_W'(PULSE_CYC);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign active = cfg_i.irq_en && (cfg_i.pulse ? (cnt_q != '0) : pending_i);
  assign int_o  = cfg_i.pol ? active : ~active;
endmodule

// File: rtl/dint_unit.sv
module dint_unit
  import dint_pkg::*;
#(
  parameter int N_EP      = 14,
  parameter int REG_W     = 32,
  parameter int WORD_W    = 16,
  parameter int PULSE_CYC = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic [7:0]        cmd_i,
  input  logic              data_we_i,
  input  logic              data_re_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] rd_data_o,
  input  logic [NUM_BUS_EVT-1:0] bus_evt_i,
  input  logic [N_EP-1:0]   ep_evt_i,
  output logic              int_o
);
  localparam int EVT_N = NUM_BUS_EVT + N_EP;

  logic [REG_W-1:0] evt_all, enable, status, clr_mask;
  logic             en_wr, new_evt;
  cfg_t             cfg;

  assign evt_all = REG_W'({ep_evt_i, bus_evt_i});

  dint_regs #(.REG_W(REG_W), .WORD_W(WORD_W)) u_regs (
    .clk_i, .rst_ni, .cmd_we_i, .cmd_i, .data_we_i, .data_re_i, .wr_data_i,
    .status_i(status), .rd_data_o, .enable_o(enable), .clr_mask_o(clr_mask),
    .en_wr_o(en_wr), .cfg_o(cfg)
  );

  dint_capture #(.REG_W(REG_W)) u_cap (
    .clk_i, .rst_ni, .evt_i(evt_all), .enable_i(enable), .clr_i(clr_mask),
    .status_o(status), .new_o(new_evt)
  );

  dint_pin #(.PULSE_CYC(PULSE_CYC)) u_pin (
    .clk_i, .rst_ni, .cfg_i(cfg), .pending_i(|status), .new_i(new_evt), .int_o
  );
endmodule

// File: rtl/dint_unit_chk.sv
module dint_unit_chk
  import dint_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int EVT_N = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             int_o,
  input logic [REG_W-1:0] status_i,
  input logic [REG_W-1:0] enable_i,
  input logic             en_wr_i,
  input cfg_t             cfg_i,
  input logic             bus_rst_i
);
  logic act;
  assign act = (int_o == cfg_i.pol);

  AST_NO_LATCH_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i & ~$past(status_i) & ~$past(enable_i)) == '0); // R4

  AST_PIN_IDLE_NO_IRQ_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i.irq_en |-> !act); // R10

  AST_LEVEL_FOLLOWS_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.irq_en && !cfg_i.pulse) |-> (act == (status_i != '0))); // R7

  AST_PULSE_NOT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.irq_en && cfg_i.pulse && $stable(cfg_i) && $rose(act))
      |=> (act || !$stable(cfg_i))); // R8

  AST_BUS_RESET_KEEPS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rst_i && !en_wr_i) |=> $stable(enable_i)); // R11

  if (EVT_N < REG_W) begin : g_pad
    AST_UNUSED_STATUS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      status_i[REG_W-1:EVT_N] == '0); // R3
  end
endmodule

bind dint_unit dint_unit_chk #(.REG_W(REG_W), .EVT_N(EVT_N)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .int_o(int_o), .status_i(status),
  .enable_i(enable), .en_wr_i(en_wr), .cfg_i(cfg), .bus_rst_i(bus_evt_i[0])
);

// File: tb/dint_unit_tb.sv
module dint_unit_tb;
  import dint_pkg::*;

  localparam int N_EP = 14;
  localparam int PULSE_CYC = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_we = 1'b0, data_we = 1'b0, data_re = 1'b0;
  logic [7:0]  cmd = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [19:0] ev = '0;
  logic        int_o;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  dint_unit #(.N_EP(N_EP), .PULSE_CYC(PULSE_CYC)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_we_i(cmd_we), .cmd_i(cmd),
    .data_we_i(data_we), .data_re_i(data_re), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .bus_evt_i(ev[5:0]), .ep_evt_i(ev[19:6]), .int_o(int_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_cmd(logic [7:0] c);
    cmd = c; cmd_we = 1'b1;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic wr_word(logic [15:0] w);
    wr_data = w; data_we = 1'b1;
    @(negedge clk); data_we = 1'b0;
  endtask

  task automatic rd_word(output logic [15:0] w);
    w = rd_data; data_re = 1'b1;
    @(negedge clk); data_re = 1'b0;
  endtask

  task automatic wr32(logic [7:0] c, logic [31:0] v);
    send_cmd(c); wr_word(v[15:0]); wr_word(v[31:16]);
  endtask

  task automatic rd32(logic [7:0] c, output logic [31:0] v);
    logic [15:0] lo, hi;
    send_cmd(c); rd_word(lo); rd_word(hi);
    v = {hi, lo};
  endtask

  task automatic set_cfg(logic irq, logic pulse, logic pol);
    send_cmd(CMD_CFG_WR); wr_word({13'b0, pol, pulse, irq});
  endtask

  task automatic pulse_ev(int b);
    ev[b] = 1'b1; @(negedge clk); ev[b] = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 pin idle", {31'b0, int_o}, 32'd1);
    rd32(CMD_EN_RD, v);   check("R1 enable", v, 32'h0);
    rd32(CMD_STAT_RD, v); check("R1 status", v, 32'h0);
    rd32(CMD_CFG_RD, v);  check("R1 cfg", v, 32'h0);
  endtask

  task automatic t_enable_rw();
    logic [31:0] v;
    logic [15:0] w;
    wr32(CMD_EN_WR, 32'hA5C3_0F1E);
    send_cmd(CMD_EN_RD); rd_word(w);
    check("R2 first word low", {16'b0, w}, 32'h0F1E);
    rd32(CMD_EN_RD, v); check("R2 enable readback", v, 32'hA5C3_0F1E);
    wr32(CMD_EN_WR, 32'h0);
  endtask

  task automatic t_capture_level();
    logic [31:0] v;
    set_cfg(1'b1, 1'b0, 1'b0);
    wr32(CMD_EN_WR, 32'h0000_0108);   // SOF (bit 3), endpoint 2 (bit 8)
    pulse_ev(3);
    check("R7 pin active after latch", {31'b0, int_o}, 32'd0);
    rd32(CMD_STAT_RD, v); check("R3 sof latched", v, 32'h8);
    pulse_ev(8);
    rd32(CMD_STAT_RD, v); check("R3 ep2 latched", v, 32'h108);
    wr32(CMD_STAT_CLR, 32'h8);
    check("R7 pin held by pending ep2", {31'b0, int_o}, 32'd0);
    send_cmd(CMD_STAT_CLR); wr_word(16'h0100);
    check("R7 pin released after last clear", {31'b0, int_o}, 32'd1);
    wr_word(16'h0);
    rd32(CMD_STAT_RD, v); check("R6 status cleared", v, 32'h0);
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    wr32(CMD_EN_WR, 32'h0000_0008);
    pulse_ev(4);
    check("R4 pin idle", {31'b0, int_o}, 32'd1);
    rd32(CMD_STAT_RD, v); check("R4 not latched", v, 32'h0);
  endtask

  task automatic t_late_enable();
    logic [31:0] v;
    wr32(CMD_EN_WR, 32'h0);
    ev[5] = 1'b1; @(negedge clk);
    wr32(CMD_EN_WR, 32'h20);
    repeat (3) @(negedge clk);
    check("R5 late enable pin idle", {31'b0, int_o}, 32'd1);
    rd32(CMD_STAT_RD, v); check("R5 late enable not latched", v, 32'h0);
    wr32(CMD_EN_WR, 32'h0);
    ev[5] = 1'b0; @(negedge clk);
    send_cmd(CMD_EN_WR);
    wr_data = 16'h0020; data_we = 1'b1; ev[5] = 1'b1;
    @(negedge clk); data_we = 1'b0;
    wr_word(16'h0);
    rd32(CMD_STAT_RD, v); check("R5 same-cycle enable not latched", v, 32'h0);
    ev[5] = 1'b0; @(negedge clk);
    pulse_ev(5);
    rd32(CMD_STAT_RD, v); check("R5 later edge latched", v, 32'h20);
    wr32(CMD_STAT_CLR, 32'hFFFF_FFFF);
  endtask

  task automatic t_clear_race();
    logic [31:0] v;
    wr32(CMD_EN_WR, 32'h40);
    pulse_ev(6);
    send_cmd(CMD_STAT_CLR);
    wr_data = 16'h0040; data_we = 1'b1; ev[6] = 1'b1;
    @(negedge clk); data_we = 1'b0; ev[6] = 1'b0;
    wr_word(16'h0);
    rd32(CMD_STAT_RD, v); check("R6 set wins over clear", v, 32'h40);
    wr32(CMD_STAT_CLR, 32'h40);
    rd32(CMD_STAT_RD, v); check("R6 plain clear", v, 32'h0);
  endtask

  task automatic t_pulse();
    logic [31:0] v;
    int cnt;
    set_cfg(1'b1, 1'b1, 1'b0);
    wr32(CMD_EN_WR, 32'h2);
    for (int k = 0; k < 2; k++) begin
      ev[1] = 1'b1; @(negedge clk); ev[1] = 1'b0;
      cnt = 0;
      for (int i = 0; i < 20; i++) begin
        if (int_o == 1'b0) cnt++;
        @(negedge clk);
      end
      check("R8 pulse width", cnt, PULSE_CYC);
      check("R8 pin idle while pending", {31'b0, int_o}, 32'd1);
    end
    rd32(CMD_STAT_RD, v); check("R8 status still pending", v, 32'h2);
    wr32(CMD_STAT_CLR, 32'h2);
  endtask

  task automatic t_polarity();
    set_cfg(1'b1, 1'b0, 1'b1);
    check("R9 idle low when active-high", {31'b0, int_o}, 32'd0);
    wr32(CMD_EN_WR, 32'h4);
    pulse_ev(2);
    check("R9 asserted high", {31'b0, int_o}, 32'd1);
    wr32(CMD_STAT_CLR, 32'h4);
    check("R9 released low", {31'b0, int_o}, 32'd0);
  endtask

  task automatic t_irq_off();
    logic [31:0] v;
    set_cfg(1'b0, 1'b0, 1'b0);
    wr32(CMD_EN_WR, 32'h8);
    pulse_ev(3);
    check("R10 pin idle with global off", {31'b0, int_o}, 32'd1);
    rd32(CMD_STAT_RD, v); check("R10 still latched", v, 32'h8);
    set_cfg(1'b1, 1'b0, 1'b0);
    check("R10 pin asserts on global enable", {31'b0, int_o}, 32'd0);
    wr32(CMD_STAT_CLR, 32'h8);
  endtask

  task automatic t_bus_reset();
    logic [31:0] v;
    wr32(CMD_EN_WR, 32'h1234_0001);
    set_cfg(1'b1, 1'b0, 1'b1);
    pulse_ev(0);
    rd32(CMD_STAT_RD, v); check("R11 bus reset latched", v, 32'h1);
    rd32(CMD_EN_RD, v);   check("R11 enable kept", v, 32'h1234_0001);
    rd32(CMD_CFG_RD, v);  check("R12 cfg readback", v, 32'h5);
    wr32(CMD_STAT_CLR, 32'h1);
    check("R9 R11 pin idle after clear", {31'b0, int_o}, 32'd0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable_rw();
    t_capture_level();
    t_disabled();
    t_late_enable();
    t_clear_race();
    t_pulse();
    t_polarity();
    t_irq_off();
    t_bus_reset();
    finish_run();
  end
endmodule